// File: doc/BRIEF.md
# Predicated reversed vector unsigned divider

The block divides every lane of a fixed-length vector in parallel, using unsigned integers and reversed operands. In each active lane the element of the second source vector is the dividend. The element in the same lane of the first source vector is the divisor. The quotient replaces the first-source element, so the first source doubles as the destination. Lanes that the predicate switches off pass the first-source element through unchanged. A zero divisor gives a quotient of zero and raises no flag.

A 2-bit size code selects the element width, which is 8 shifted left by the code. Only 32-bit and 64-bit elements are legal. The predicate has one bit per byte of the vector. A lane counts as active when the bit at its lowest byte is set. A caller pulses `start` while the block is idle and waits for the one-cycle `done`. Every lane runs a restoring radix-2 divider, one quotient bit per clock. An illegal size code finishes at once with `undef` and leaves the result equal to the first source.

Top module: `rvdiv_top`

## Requirements
- R1: Size code 2'b10 selects 32-bit lanes (VLEN/32 lanes) and code 2'b11 selects 64-bit lanes (VLEN/64 lanes). Lane e occupies bits [e*esize +: esize] of each vector.
- R2: In an active lane the result is the low esize bits of floor(src_m lane / src_dn lane). A dividend smaller than its divisor gives 0.
- R3: An active lane whose src_dn element is zero yields exactly 0, and `undef` stays low.
- R4: An inactive lane yields its src_dn element unchanged. With no active lane the whole result equals src_dn.
- R5: Lane e is active exactly when pred bit e*(esize/8) is 1. Every other predicate bit has no effect.
- R6: Take the clock edge that accepts a legal start as edge 0. `busy` is high from then until edge esize. At edge esize `busy` falls, `done` rises for exactly one cycle, and the result is valid from that edge until the next accepted start.
- R7: Size code 2'b00 or 2'b01 raises `done` and `undef` together for one cycle right after the accepting edge. `busy` stays low and the result equals the src_dn value sampled with start.
- R8: `start` is ignored while `busy` is high. A run in progress keeps its operands and finishes with its own result.
- R9: After reset `busy`, `done` and `undef` are low and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation, sampled while idle |
| size | input | 2 | Element size code, esize = 8 << size |
| src_dn | input | VLEN | First source vector: divisors and merge values |
| src_m | input | VLEN | Second source vector: dividends |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse, result valid |
| undef | output | 1 | Illegal size code, pulses with done |
| result | output | VLEN | Quotient vector merged with src_dn |

## Verification
A legal operation has `done` due exactly esize clock edges after the edge that accepted start: 32 edges for 32-bit lanes and 64 for 64-bit lanes. An illegal size has it due on the very next edge. The bench drives inputs on falling edges and counts falling edges from acceptance until `done` shows. It then compares that count with the expected latency, and at that point it checks `result` and `undef` against a behavioural model. One falling edge later it confirms that `done` has dropped. Right after acceptance it also scrambles the source inputs, which shows that the operands were captured at the accepting edge.

// File: rtl/rvdiv_pkg.sv
package rvdiv_pkg;
   localparam int EW_LO = 32;
   localparam int EW_HI = 64;
   localparam int CNT_W = $clog2(EW_HI + 1);

   function automatic logic size_legal(input logic [1:0] sz);
      return sz[1];
   endfunction

   function automatic logic size_wide(input logic [1:0] sz);
      return sz[0];
   endfunction
endpackage

// File: rtl/rvdiv_lane.sv
module rvdiv_lane #(
   parameter int W      = 64,
   parameter int NARROW = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic         wide,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quo
);
   localparam int PRESHIFT = W - NARROW;

   logic [W-1:0] rem_q, dq_q, dvs_q;
   logic [W:0]   trial, diff;
   logic         fits;

   initial begin
      if (NARROW > W || NARROW < 1) $error("rvdiv_lane: NARROW must be 1..W");
   end

   always_comb begin
      trial = {rem_q, dq_q[W-1]};
      diff  = trial - {1'b0, dvs_q};
      fits  = ~diff[W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dq_q  <= '0;
         dvs_q <= '0;
      end else if (load) begin
         rem_q <= '0;
         dq_q  <= wide ? dividend : (dividend << PRESHIFT);
         dvs_q <= divisor;
      end else if (step) begin
         rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
         dq_q  <= {dq_q[W-2:0], fits};
      end
   end

   assign quo = (dvs_q == '0) ? '0 : dq_q;

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dvs_q != '0) |=> (rem_q < dvs_q)); // R2
endmodule

// File: rtl/rvdiv_ctrl.sv
module rvdiv_ctrl
   import rvdiv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic legal,
   input  logic wide,
   output logic load,
   output logic ill_take,
   output logic step,
   output logic busy,
   output logic done,
   output logic undef
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, done_q, undef_q;
   logic             take;

   assign take     = start & ~busy_q;
   assign load     = take & legal;
   assign ill_take = take & ~legal;
   assign step     = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         undef_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         undef_q <= 1'b0;
         if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= wide ? CNT_W'(EW_HI) : CNT_W'(EW_LO);
         end else if (ill_take) begin
            done_q  <= 1'b1;
            undef_q <= 1'b1;
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy  = busy_q;
   assign done  = done_q;
   assign undef = undef_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done || undef)); // R6
   AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && !undef)); // R6
   AST_UNDEF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> (done && !busy)); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q > CNT_W'(1)) |=> (busy && $past(cnt_q) - cnt_q == CNT_W'(1))); // R8
endmodule

// File: rtl/rvdiv_merge.sv
module rvdiv_merge
   import rvdiv_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic [VLEN/EW_HI*EW_HI-1:0] q_even,
   input  logic [VLEN/EW_HI*EW_LO-1:0] q_odd,
   input  logic [VLEN-1:0]             op1,
   input  logic [VLEN/EW_LO-1:0]       act,
   input  logic                        wide,
   input  logic                        bypass,
   output logic [VLEN-1:0]             res
);
   localparam int N_HI = VLEN / EW_HI;
   localparam int N_LO = VLEN / EW_LO;

   logic [VLEN-1:0] res_lo, res_hi;

   always_comb begin
      for (int i = 0; i < N_LO; i++) begin
         if (!act[i])
            res_lo[EW_LO*i +: EW_LO] = op1[EW_LO*i +: EW_LO];
         else if (i % 2 == 0)
            res_lo[EW_LO*i +: EW_LO] = q_even[EW_HI*(i/2) +: EW_LO];
         else
            res_lo[EW_LO*i +: EW_LO] = q_odd[EW_LO*(i/2) +: EW_LO];
      end
      for (int k = 0; k < N_HI; k++) begin
         res_hi[EW_HI*k +: EW_HI] = act[2*k] ? q_even[EW_HI*k +: EW_HI]
                                             : op1[EW_HI*k +: EW_HI];
      end
      res = bypass ? op1 : (wide ? res_hi : res_lo);
   end
endmodule

// File: rtl/rvdiv_top.sv
module rvdiv_top
   import rvdiv_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        size,
   input  logic [VLEN-1:0]   src_dn,
   input  logic [VLEN-1:0]   src_m,
   input  logic [VLEN/8-1:0] pred,
   output logic              busy,
   output logic              done,
   output logic              undef,
   output logic [VLEN-1:0]   result
);
   localparam int NU   = VLEN / EW_LO;
   localparam int N_HI = VLEN / EW_HI;

   if (VLEN % EW_HI != 0 || VLEN < EW_HI) begin : g_bad_vlen
      $error("rvdiv_top: VLEN must be a positive multiple of 64");
   end

   logic              legal_in, wide_in;
   logic              load, ill_take, step;
   logic [NU-1:0]     act_in, act_q;
   logic [VLEN-1:0]   op1_q;
   logic              wide_q, bypass_q;
   logic [N_HI*EW_HI-1:0] q_even;
   logic [N_HI*EW_LO-1:0] q_odd;

   assign legal_in = size_legal(size);
   assign wide_in  = size_wide(size);

   function automatic logic [VLEN/8-1:0] base_mask(input logic wd);
      logic [VLEN/8-1:0] m;
      m = '0;
      for (int i = 0; i < NU; i++) m[4*i] = !wd || (i % 2 == 0);
      return m;
   endfunction

   rvdiv_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .legal(legal_in), .wide(wide_in),
      .load(load), .ill_take(ill_take), .step(step),
      .busy(busy), .done(done), .undef(undef)
   );

   for (genvar i = 0; i < NU; i++) begin : g_lane
      if (i % 2 == 0) begin : g_even
         logic [EW_HI-1:0] dvd, dvs;
         assign act_in[i] = pred[4*i];
         assign dvd = wide_in ? src_m[EW_LO*i +: EW_HI]
                              : {{(EW_HI-EW_LO){1'b0}}, src_m[EW_LO*i +: EW_LO]};
         assign dvs = wide_in ? src_dn[EW_LO*i +: EW_HI]
                              : {{(EW_HI-EW_LO){1'b0}}, src_dn[EW_LO*i +: EW_LO]};
         rvdiv_lane #(.W(EW_HI), .NARROW(EW_LO)) u_div (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step), .wide(wide_in),
            .dividend(dvd), .divisor(dvs), .quo(q_even[EW_HI*(i/2) +: EW_HI])
         );
      end else begin : g_odd
         assign act_in[i] = pred[4*i] & ~wide_in;
         rvdiv_lane #(.W(EW_LO), .NARROW(EW_LO)) u_div (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step), .wide(1'b0),
            .dividend(src_m[EW_LO*i +: EW_LO]), .divisor(src_dn[EW_LO*i +: EW_LO]),
            .quo(q_odd[EW_LO*(i/2) +: EW_LO])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op1_q    <= '0;
         act_q    <= '0;
         wide_q   <= 1'b0;
         bypass_q <= 1'b1;
      end else if (load) begin
         op1_q    <= src_dn;
         act_q    <= act_in;
         wide_q   <= wide_in;
         bypass_q <= 1'b0;
      end else if (ill_take) begin
         op1_q    <= src_dn;
         bypass_q <= 1'b1;
      end
   end

   rvdiv_merge #(.VLEN(VLEN)) u_merge (
      .q_even(q_even), .q_odd(q_odd), .op1(op1_q), .act(act_q),
      .wide(wide_q), .bypass(bypass_q), .res(result)
   );

   AST_PRED_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (load && ((pred & base_mask(wide_in)) == '0)) |=> (act_q == '0)); // R5
   AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !undef && !wide_q && act_q[0] && op1_q[EW_LO-1:0] == '0)
      |-> (result[EW_LO-1:0] == '0)); // R3
   AST_UNDEF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> (result == op1_q)); // R7
endmodule

// File: tb/sim_rvdiv_top.sv
module sim_rvdiv_top;
   localparam int VLEN = 256;
   localparam int PW   = VLEN / 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      size = 2'b10;
   logic [VLEN-1:0] src_dn = '0, src_m = '0;
   logic [PW-1:0]   pred = '0;
   logic            busy, done, undef;
   logic [VLEN-1:0] result;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rvdiv_top #(.VLEN(VLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .size(size), .src_dn(src_dn),
      .src_m(src_m), .pred(pred), .busy(busy), .done(done), .undef(undef),
      .result(result)
   );

   task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                      input logic [VLEN-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a, b,
                                             input logic [PW-1:0] p, input logic [1:0] sz);
      logic [VLEN-1:0] r;
      int esz;
      r = a;
      if (sz[1]) begin
         esz = 8 << sz;
         for (int e = 0; e < VLEN / esz; e++) begin
            if (p[e * (esz / 8)]) begin
               logic [63:0] d, n;
               d = (esz == 64) ? a[64*e +: 64] : {32'd0, a[32*e +: 32]};
               n = (esz == 64) ? b[64*e +: 64] : {32'd0, b[32*e +: 32]};
               if (esz == 64) r[64*e +: 64] = (d == 0) ? 64'd0 : n / d;
               else           r[32*e +: 32] = (d == 0) ? 32'd0 : 32'(n / d);
            end
         end
      end
      return r;
   endfunction

   function automatic logic [VLEN-1:0] rnd();
      logic [VLEN-1:0] v;
      for (int i = 0; i < VLEN / 32; i++) v[32*i +: 32] = $urandom;
      return v;
   endfunction

   task automatic run(input logic [VLEN-1:0] a, b, input logic [PW-1:0] p,
                      input logic [1:0] sz, input string req, input bit poke);
      logic [VLEN-1:0] exp;
      int cnt, lat;
      bit legal;
      legal = sz[1];
      lat   = legal ? (8 << sz) : 0;
      exp   = model(a, b, p, sz);
      @(negedge clk);
      src_dn = a; src_m = b; pred = p; size = sz; start = 1'b1;
      @(negedge clk);
      start = 1'b0; src_dn = ~a; src_m = ~b; pred = ~p;
      chk(busy == legal, {req, " R6 busy after accept"}, VLEN'(busy), VLEN'(legal));
      cnt = 0;
      while (!done && cnt < 200) begin
         start = poke && (cnt == 5);
         if (poke && cnt == 5) size = 2'b00;
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      chk(cnt == lat, {req, " R6 latency"}, VLEN'(cnt), VLEN'(lat));
      chk(undef == !legal, {req, " R7 undef"}, VLEN'(undef), VLEN'(!legal));
      chk(result == exp, {req, " result"}, result, exp);
      @(negedge clk);
      chk(done == 1'b0, {req, " R6 done one cycle"}, VLEN'(done), '0);
      chk(result == exp, {req, " result held"}, result, exp);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !undef, "R9 flags after reset", VLEN'({busy, done, undef}), '0);
      chk(result == '0, "R9 result after reset", result, '0);
   endtask

   task automatic t_rand();
      for (int k = 0; k < 3; k++) begin
         run(rnd(), rnd(), '1, 2'b10, "R1 R2 random 32-bit", 0);
         run(rnd() & {8{32'h0000_0FFF}}, rnd(), '1, 2'b10, "R2 small divisors 32-bit", 0);
         run(rnd() & {4{64'h0000_0000_00FF_FFFF}}, rnd(), '1, 2'b11, "R1 R2 random 64-bit", 0);
         run(rnd(), rnd(), PW'($urandom), 2'b11, "R4 mixed predicate 64-bit", 0);
         run(rnd() >> 4, rnd(), PW'($urandom), 2'b10, "R4 mixed predicate 32-bit", 0);
      end
   endtask

   task automatic t_zero();
      logic [VLEN-1:0] a;
      a = rnd() & {4{64'h0000_0000_FFFF_FFFF}};
      run(a, rnd(), '1, 2'b10, "R3 zero divisor 32-bit", 0);
      a = rnd() & {2{128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF}};
      run(a, rnd(), '1, 2'b11, "R3 zero divisor 64-bit", 0);
      run('0, '1, '1, 2'b11, "R3 all zero divisors", 0);
   endtask

   task automatic t_small();
      logic [VLEN-1:0] a;
      a = rnd() | {8{32'h8000_0000}};
      run(a, a >> 1 & {8{32'h7FFF_FFFF}}, '1, 2'b10, "R2 dividend below divisor", 0);
      run(a, a, '1, 2'b11, "R2 equal operands", 0);
   endtask

   task automatic t_ones();
      run('1, '1, '1, 2'b10, "R2 all ones 32-bit", 0);
      run('1, '1, '1, 2'b11, "R2 all ones 64-bit", 0);
      run({4{64'd1}}, '1, '1, 2'b11, "R2 divide by one 64-bit", 0);
   endtask

   task automatic t_inactive();
      run(rnd(), rnd(), '0, 2'b10, "R4 no active lane", 0);
      run(rnd(), rnd(), ~{8{4'h1}}, 2'b10, "R5 non-base bits 32-bit", 0);
      run(rnd(), rnd(), ~{4{8'h01}}, 2'b11, "R5 non-base bits 64-bit", 0);
      run(rnd(), rnd(), {8{4'h1}}, 2'b10, "R5 base bits only 32-bit", 0);
   endtask

   task automatic t_illegal();
      run(rnd(), rnd(), '1, 2'b00, "R7 size code 00", 0);
      run(rnd(), rnd(), '1, 2'b01, "R7 size code 01", 0);
   endtask

   task automatic t_busy_start();
      run(rnd(), rnd(), '1, 2'b10, "R8 start while busy", 1);
      chk(!busy, "R8 idle after run", VLEN'(busy), '0);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rand();
      t_zero();
      t_small();
      t_ones();
      t_inactive();
      t_illegal();
      t_busy_start();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule